// File: doc/BRIEF.md
# Receive FIFO Forwarding Controller

This block sits between a MAC's receive byte stream and the receive DMA. It writes each incoming frame into a small FIFO and decides when the DMA may start taking the frame out. In cut-through mode a frame is handed over once it has passed the address filter and enough bytes have arrived to reach a selectable threshold. In store-and-forward mode a frame is handed over only after its final byte is stored. Frames that fail the address filter, frames with no filter verdict, and short errored frames are deleted from the FIFO before the DMA sees any byte of them.

Frames are deleted by rewinding the write pointer to the start of the frame. A frame can therefore only be removed while no byte of it has been released. The DMA side sees a request line, the byte at the head of the FIFO with end and error marks, and a pop strobe. A flush command discards the frame at the head of the FIFO up to and including its end-marked byte.

Top module: `rxf_fwd_ctrl`

## Requirements
- R1: With `store_fwd`=0, a frame whose filter verdict is pass (or `rx_all`=1) is released once its stored length is at least (`thr_sel`+1)×32 bytes. The encodings are 00=32, 01=64, 10=96 and 11=128 bytes. `dma_req` rises in the cycle after the write of the byte that meets the threshold. If the verdict arrives later than that byte, `dma_req` rises in the cycle after the verdict.
- R2: With `store_fwd`=1, no byte of a frame is released before its end-marked byte is written. `dma_req` rises in the cycle after that write.
- R3: A frame whose verdict is fail (`filt_valid`=1 with `filt_pass`=0) is removed while `rx_all`=0, and is forwarded while `rx_all`=1. A frame that ends with no verdict is removed unless `rx_all`=1.
- R4: When `runt_drop`=1, a frame that ends with `in_err`=1 and fewer than 64 bytes, with none of its bytes released, is removed. When `runt_drop`=0 such a frame is forwarded, with the error mark on its final byte.
- R5: A passed frame that ends before reaching the threshold is released at its end. `dma_req` rises in the cycle after its end byte is written.
- R6: A one-cycle `flush_req` sets `flush_busy` in the next cycle. While `flush_busy` is set, `dma_req` is low and released bytes are discarded one per cycle. `flush_busy` clears after the end-marked byte is discarded. The following frame is delivered intact.
- R7: Delivered bytes come out in arrival order. `dma_last`=1 marks only the final byte of a frame, and `dma_err`=1 appears on that final byte when `in_err` was set with the end byte.
- R8: A frame that meets a full FIFO is removed if none of it is released. If part of it is released, its later bytes are lost, but its end byte is still stored, with the error mark set. One FIFO slot is held back for that end byte.
- R9: After reset, `dma_req` and `flush_busy` are 0.
- R10: `dma_pop` has no effect while `dma_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Receive byte valid |
| in_data | input | 8 | Receive byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Frame ended in error (with `in_eof`) |
| filt_valid | input | 1 | Address-filter verdict strobe for the current frame |
| filt_pass | input | 1 | Verdict: 1 = pass |
| rx_all | input | 1 | Forward frames regardless of the verdict |
| store_fwd | input | 1 | 1 = store-and-forward, 0 = threshold mode |
| thr_sel | input | 2 | Threshold select (00/01/10/11 = 32/64/96/128 bytes) |
| runt_drop | input | 1 | Remove short errored frames |
| dma_req | output | 1 | Released bytes are available to the DMA |
| dma_pop | input | 1 | DMA takes the head byte |
| dma_data | output | 8 | Head byte |
| dma_last | output | 1 | Head byte ends its frame |
| dma_err | output | 1 | Head byte carries the error mark |
| flush_req | input | 1 | Discard the head frame |
| flush_busy | output | 1 | Flush in progress |

## Verification
A flush running on the read side can coincide with a new frame being released on the write side. Both move the boundary between released and unreleased bytes in the same cycle. The bench completes one short frame and then streams a second frame in threshold mode. It pulses `flush_req` in the same cycle in which the second frame's 64th byte is written. It then checks that `flush_busy` is set and `dma_req` is low, that the first frame disappears, and that the second frame is delivered complete and in order.

// File: rtl/rxf_pkg.sv
// Package: shared types for the receive FIFO forwarding controller.
// Assumes a byte-wide FIFO where each entry carries an end mark and an error mark.
package rxf_pkg;

    // One FIFO entry: frame-end mark, error mark, payload byte.
    typedef struct packed {
        logic       last;
        logic       err;
        logic [7:0] data;
    } rxf_ent_t;

endpackage

// File: rtl/rxf_store.sv
// Module: byte storage for the receive FIFO.
// One write port and one asynchronous read port. It holds no pointers and is not reset.
// Assumes DEPTH is a power of two.
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  rxf_ent_t      wdata,
    input  logic [AW-1:0] raddr,
    output rxf_ent_t      rdata
);

    rxf_ent_t mem [DEPTH];

    // Store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the head entry combinationally.
    assign rdata = mem[raddr];

endmodule

// File: rtl/rxf_admit.sv
// Module: write-side frame admission.
// Writes MAC bytes into the FIFO and tracks the length, filter verdict and release state of each frame.
// It releases a frame by moving the release pointer, and removes a frame by rewinding the write pointer to the frame start.
// Assumes the read pointer never passes the release pointer.
module rxf_admit
    import rxf_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int LEN_W    = 16,
    parameter int THR_UNIT = 32,
    parameter int RUNT_LEN = 64,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic          in_err,
    input  logic          filt_valid,
    input  logic          filt_pass,
    input  logic          rx_all,
    input  logic          store_fwd,
    input  logic [1:0]    thr_sel,
    input  logic          runt_drop,
    input  logic [PW-1:0] rd_ptr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output rxf_ent_t      wdata,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rel_ptr
);

    logic             in_frame_q, skip_q, rel_q, vseen_q, vok_q, ovf_q;
    logic [LEN_W-1:0] len_q;
    logic [PW-1:0]    wr_q, start_q, relp_q;

    logic             n_in_frame, n_skip, n_rel, n_vseen, n_vok, n_ovf;
    logic [LEN_W-1:0] n_len;
    logic [PW-1:0]    n_wr, n_start, n_relp;

    logic             new_fr, act, c_skip, c_rel, c_vseen, c_vok, c_ovf;
    logic [LEN_W-1:0] c_len, inc_len, thr;
    logic [PW-1:0]    c_start, occ, free;
    logic             fwd_ok, flt_fail, fits, runt;

    // Derive the threshold byte count from the select code.
    assign thr = LEN_W'((32'(thr_sel) + 32'd1) * THR_UNIT);

    // Compute occupancy and free space from the two pointers.
    assign occ  = wr_q - rd_ptr;
    assign free = PW'(DEPTH) - occ;

    // Select the frame context: a start byte begins a fresh one.
    always_comb begin
        new_fr  = in_valid & in_sof;
        act     = new_fr | in_frame_q;
        c_skip  = new_fr ? 1'b0 : skip_q;
        c_rel   = new_fr ? 1'b0 : rel_q;
        c_vseen = new_fr ? 1'b0 : vseen_q;
        c_vok   = new_fr ? 1'b0 : vok_q;
        c_ovf   = new_fr ? 1'b0 : ovf_q;
        c_len   = new_fr ? '0 : len_q;
        c_start = new_fr ? wr_q : start_q;
        inc_len = (c_len == '1) ? c_len : c_len + LEN_W'(1);
    end

    // Fold in a verdict that arrives this cycle and classify the frame.
    always_comb begin
        fwd_ok   = rx_all | (c_vseen | filt_valid) & (filt_valid ? filt_pass : c_vok);
        flt_fail = ~rx_all & (c_vseen | filt_valid) & ~(filt_valid ? filt_pass : c_vok);
        fits     = in_eof ? (free >= PW'(1)) : (free >= PW'(2));
        runt     = runt_drop & in_err & (inc_len < LEN_W'(RUNT_LEN));
    end

    // Decide write, release, rewind and skip for this cycle.
    always_comb begin
        n_in_frame = act;
        n_skip     = c_skip;
        n_rel      = c_rel;
        n_vseen    = c_vseen | filt_valid;
        n_vok      = filt_valid ? filt_pass : c_vok;
        n_ovf      = c_ovf;
        n_len      = c_len;
        n_wr       = wr_q;
        n_start    = c_start;
        n_relp     = relp_q;
        we         = 1'b0;
        wdata      = '{last: in_eof, err: in_err | c_ovf, data: in_data};
        if (act) begin
            if (c_skip) begin
                if (in_valid && in_eof) begin
                    n_in_frame = 1'b0;
                    n_skip     = 1'b0;
                end
            end else if (flt_fail && !c_rel) begin
                n_wr       = c_start;
                n_skip     = ~(in_valid & in_eof);
                n_in_frame = ~(in_valid & in_eof);
            end else if (in_valid && !fits) begin
                if (c_rel) begin
                    n_ovf = 1'b1;
                end else begin
                    n_wr       = c_start;
                    n_skip     = ~in_eof;
                    n_in_frame = ~in_eof;
                end
            end else if (in_valid) begin
                we    = 1'b1;
                n_wr  = wr_q + PW'(1);
                n_len = inc_len;
                if (in_eof) begin
                    n_in_frame = 1'b0;
                    if (!c_rel && (runt || !fwd_ok)) begin
                        n_wr = c_start;
                    end else begin
                        n_rel  = 1'b1;
                        n_relp = wr_q + PW'(1);
                    end
                end else if (c_rel || (!store_fwd && fwd_ok && inc_len >= thr)) begin
                    n_rel  = 1'b1;
                    n_relp = wr_q + PW'(1);
                end
            end else if (!c_rel && !store_fwd && fwd_ok && c_len != '0 && c_len >= thr) begin
                n_rel  = 1'b1;
                n_relp = wr_q;
            end
        end
    end

    // Register the write-side frame state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            skip_q     <= 1'b0;
            rel_q      <= 1'b0;
            vseen_q    <= 1'b0;
            vok_q      <= 1'b0;
            ovf_q      <= 1'b0;
            len_q      <= '0;
            wr_q       <= '0;
            start_q    <= '0;
            relp_q     <= '0;
        end else begin
            in_frame_q <= n_in_frame;
            skip_q     <= n_skip;
            rel_q      <= n_rel;
            vseen_q    <= n_vseen;
            vok_q      <= n_vok;
            ovf_q      <= n_ovf;
            len_q      <= n_len;
            wr_q       <= n_wr;
            start_q    <= n_start;
            relp_q     <= n_relp;
        end
    end

    assign waddr   = wr_q[AW-1:0];
    assign wr_ptr  = wr_q;
    assign rel_ptr = relp_q;

endmodule

// File: rtl/rxf_drain.sv
// Module: read-side drain and flush engine.
// Offers released bytes to the DMA. On a flush command it discards the head frame, one byte per cycle, through its end-marked byte.
// Assumes the release pointer only moves forward.
module rxf_drain
    import rxf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] rel_ptr,
    input  rxf_ent_t      head,
    input  logic          dma_pop,
    input  logic          flush_req,
    output logic [PW-1:0] rd_ptr,
    output logic          dma_req,
    output logic          flush_busy
);

    logic [PW-1:0] rd_q;
    logic          flush_q, avail, pop;

    // Bytes may leave only below the release pointer.
    assign avail   = rel_ptr != rd_q;
    assign dma_req = avail & ~flush_q;
    assign pop     = avail & (flush_q | dma_pop);

    // Advance the read pointer and run the flush state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= '0;
            flush_q <= 1'b0;
        end else begin
            if (pop) begin
                rd_q <= rd_q + PW'(1);
            end
            if (!flush_q) begin
                flush_q <= flush_req;
            end else if (pop && head.last) begin
                flush_q <= 1'b0;
            end
        end
    end

    assign rd_ptr     = rd_q;
    assign flush_busy = flush_q;

endmodule

// File: rtl/rxf_fwd_ctrl.sv
// Module: top of the receive FIFO forwarding controller.
// Joins the admission logic, the byte store and the drain engine.
// Assumes a well-formed MAC stream: every frame starts with in_sof and ends with in_eof.
module rxf_fwd_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int LEN_W    = 16,
    parameter int THR_UNIT = 32,
    parameter int RUNT_LEN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       in_err,
    input  logic       filt_valid,
    input  logic       filt_pass,
    input  logic       rx_all,
    input  logic       store_fwd,
    input  logic [1:0] thr_sel,
    input  logic       runt_drop,
    output logic       dma_req,
    input  logic       dma_pop,
    output logic [7:0] dma_data,
    output logic       dma_last,
    output logic       dma_err,
    input  logic       flush_req,
    output logic       flush_busy
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          we;
    logic [AW-1:0] waddr;
    rxf_ent_t      wdata, head;
    logic [PW-1:0] wr_ptr, rel_ptr, rd_ptr;

    rxf_admit #(
        .DEPTH(DEPTH), .LEN_W(LEN_W), .THR_UNIT(THR_UNIT), .RUNT_LEN(RUNT_LEN)
    ) u_admit (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
        .in_eof(in_eof), .in_err(in_err),
        .filt_valid(filt_valid), .filt_pass(filt_pass), .rx_all(rx_all),
        .store_fwd(store_fwd), .thr_sel(thr_sel), .runt_drop(runt_drop),
        .rd_ptr(rd_ptr), .we(we), .waddr(waddr), .wdata(wdata),
        .wr_ptr(wr_ptr), .rel_ptr(rel_ptr)
    );

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(rd_ptr[AW-1:0]), .rdata(head)
    );

    rxf_drain #(.DEPTH(DEPTH)) u_drain (
        .clk(clk), .rst_n(rst_n), .rel_ptr(rel_ptr), .head(head),
        .dma_pop(dma_pop), .flush_req(flush_req), .rd_ptr(rd_ptr),
        .dma_req(dma_req), .flush_busy(flush_busy)
    );

    // Present the head entry to the DMA.
    assign dma_data = head.data;
    assign dma_last = head.last;
    assign dma_err  = head.err;

endmodule

// File: rtl/rxf_fwd_chk.sv
// Module: assertion checker for rxf_fwd_ctrl, attached with bind.
// Observes the three FIFO pointers and the DMA-side handshake.
module rxf_fwd_chk #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dma_req,
    input logic          dma_last,
    input logic          flush_req,
    input logic          flush_busy,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rel_ptr,
    input logic [PW-1:0] rd_ptr
);

    logic [PW-1:0] occ, rel_gap;
    assign occ     = wr_ptr - rd_ptr;
    assign rel_gap = wr_ptr - rel_ptr;

    // R8: occupancy never exceeds the storage depth
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH));

    // R1: the release point lies between read and write pointers
    p_release_inside_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rel_gap <= occ);

    // R6: no request while a flush runs
    p_flush_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> !dma_req);

    // R6: an idle flush engine accepts a command in the next cycle
    p_flush_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_busy && flush_req) |=> flush_busy);

    // R6: discarding the end-marked byte ends the flush
    p_flush_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_busy && rel_ptr != rd_ptr && dma_last) |=> !flush_busy);

    // R10: nothing leaves the FIFO when nothing is released
    p_hold_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_ptr == rd_ptr) |=> $stable(rd_ptr));

endmodule

bind rxf_fwd_ctrl rxf_fwd_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_last(dma_last),
    .flush_req(flush_req), .flush_busy(flush_busy),
    .wr_ptr(wr_ptr), .rel_ptr(rel_ptr), .rd_ptr(rd_ptr)
);

// File: tb/rxf_fwd_ctrl_tb.sv
// Directed bench for rxf_fwd_ctrl: one task per scenario.
// Inputs are driven and outputs sampled on the falling edge.
module rxf_fwd_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0;
    logic [7:0] in_data = 0;
    logic       filt_valid = 0, filt_pass = 0, rx_all = 0, store_fwd = 0;
    logic [1:0] thr_sel = 2'b01;
    logic       runt_drop = 1;
    logic       dma_req, dma_pop = 0, dma_last, dma_err, flush_req = 0, flush_busy;
    logic [7:0] dma_data;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rxf_fwd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
        .filt_valid(filt_valid), .filt_pass(filt_pass), .rx_all(rx_all),
        .store_fwd(store_fwd), .thr_sel(thr_sel), .runt_drop(runt_drop),
        .dma_req(dma_req), .dma_pop(dma_pop), .dma_data(dma_data),
        .dma_last(dma_last), .dma_err(dma_err),
        .flush_req(flush_req), .flush_busy(flush_busy)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one byte for one cycle and return at the next falling edge.
    task automatic put(logic [7:0] d, logic s, logic e, logic er, logic fv, logic fp, logic fl);
        in_valid = 1; in_data = d; in_sof = s; in_eof = e; in_err = er;
        filt_valid = fv; filt_pass = fp; flush_req = fl;
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0;
        filt_valid = 0; flush_req = 0;
    endtask

    // Send a frame. The verdict comes with byte vpos (0 = none). If watch>0, dma_req must be low after byte watch-1 and high after byte watch.
    task automatic send(int len, logic [7:0] base, int vpos, logic vp, logic er, int watch, int flush_at, string tag);
        for (int k = 1; k <= len; k++) begin
            put(8'(base + k - 1), k == 1, k == len, er && k == len, k == vpos, vp, k == flush_at);
            if (watch > 0 && k == watch - 1) chk(dma_req == 0, {tag, " below threshold"}, int'(dma_req), 0);
            if (watch > 0 && k == watch)     chk(dma_req == 1, {tag, " at threshold"}, int'(dma_req), 1);
            if (flush_at > 0 && k == flush_at) begin
                chk(flush_busy == 1, "R6 flush accepted", int'(flush_busy), 1);
                chk(dma_req == 0, "R6 request held low during flush", int'(dma_req), 0);
            end
        end
    endtask

    // Pop a whole frame and compare every byte.
    task automatic expect_frame(int len, logic [7:0] base, logic errlast, logic [7:0] lastv, string tag);
        int bad = 0, first_i = -1, act = 0, exp = 0;
        for (int i = 0; i < len; i++) begin
            int t = 0;
            logic [7:0] ed;
            while (!dma_req && t < 2000) begin @(negedge clk); t++; end
            ed = (i == len - 1) ? lastv : 8'(base + i);
            if (!dma_req || dma_data != ed || dma_last != (i == len - 1) ||
                dma_err != (errlast && i == len - 1)) begin
                if (bad == 0) begin first_i = i; act = int'(dma_data); exp = int'(ed); end
                bad++;
            end
            dma_pop = 1; @(negedge clk); dma_pop = 0;
        end
        chk(bad == 0, {tag, " frame content"}, act, exp);
        if (bad != 0) $display("  first mismatch at byte %0d", first_i);
        chk(dma_req == 0, {tag, " FIFO empty after frame"}, int'(dma_req), 0);
    endtask

    task automatic expect_empty(string tag);
        repeat (4) @(negedge clk);
        chk(dma_req == 0, tag, int'(dma_req), 0);
    endtask

    task automatic t_reset;
        chk(dma_req == 0, "R9 reset dma_req", int'(dma_req), 0);
        chk(flush_busy == 0, "R9 reset flush_busy", int'(flush_busy), 0);
    endtask

    task automatic t_threshold;
        store_fwd = 0; rx_all = 0;
        thr_sel = 2'b01; send(100, 8'h10, 1, 1, 0, 64, 0, "R1 thr 64");
        expect_frame(100, 8'h10, 0, 8'(8'h10 + 99), "R1 R7 thr 64");
        thr_sel = 2'b00; send(40, 8'h30, 1, 1, 0, 32, 0, "R1 thr 32");
        expect_frame(40, 8'h30, 0, 8'(8'h30 + 39), "R1 thr 32");
        thr_sel = 2'b11; send(140, 8'h50, 1, 1, 0, 128, 0, "R1 thr 128");
        expect_frame(140, 8'h50, 0, 8'(8'h50 + 139), "R1 thr 128");
        thr_sel = 2'b10; send(100, 8'h70, 1, 1, 0, 96, 0, "R1 thr 96");
        expect_frame(100, 8'h70, 0, 8'(8'h70 + 99), "R1 thr 96");
        thr_sel = 2'b01; send(80, 8'h90, 70, 1, 0, 70, 0, "R1 late verdict");
        expect_frame(80, 8'h90, 0, 8'(8'h90 + 79), "R1 late verdict");
    endtask

    task automatic t_store_fwd;
        store_fwd = 1;
        send(100, 8'h05, 1, 1, 0, 100, 0, "R2 store-and-forward");
        expect_frame(100, 8'h05, 0, 8'(8'h05 + 99), "R2 store-and-forward");
        store_fwd = 0;
    endtask

    task automatic t_filter;
        send(80, 8'h20, 10, 0, 0, 0, 0, "R3");
        expect_empty("R3 failed frame removed");
        rx_all = 1;
        send(80, 8'h22, 10, 0, 0, 0, 0, "R3");
        expect_frame(80, 8'h22, 0, 8'(8'h22 + 79), "R3 receive-all keeps failed frame");
        rx_all = 0;
        send(30, 8'h24, 0, 0, 0, 0, 0, "R3");
        expect_empty("R3 frame without verdict removed");
    endtask

    task automatic t_short;
        send(20, 8'h40, 1, 1, 0, 20, 0, "R5 short frame at end");
        expect_frame(20, 8'h40, 0, 8'(8'h40 + 19), "R5 short frame");
    endtask

    task automatic t_runt;
        runt_drop = 1;
        send(40, 8'h60, 1, 1, 1, 0, 0, "R4");
        expect_empty("R4 runt removed");
        runt_drop = 0;
        send(40, 8'h62, 1, 1, 1, 40, 0, "R4 runt kept");
        expect_frame(40, 8'h62, 1, 8'(8'h62 + 39), "R4 R7 runt kept with error mark");
        runt_drop = 1;
    endtask

    task automatic t_pop_idle;
        dma_pop = 1; repeat (8) @(negedge clk); dma_pop = 0;
        send(10, 8'hA0, 1, 1, 0, 0, 0, "R10");
        expect_frame(10, 8'hA0, 0, 8'(8'hA0 + 9), "R10 pop while idle ignored");
    endtask

    task automatic t_flush;
        int t = 0;
        send(50, 8'hB0, 1, 1, 0, 50, 0, "R6 first frame");
        send(80, 8'hC0, 1, 1, 0, 0, 64, "R6");
        while (flush_busy && t < 500) begin @(negedge clk); t++; end
        chk(flush_busy == 0, "R6 flush completes", int'(flush_busy), 0);
        expect_frame(80, 8'hC0, 0, 8'(8'hC0 + 79), "R6 next frame intact");
    endtask

    task automatic t_overflow;
        send(300, 8'h00, 1, 1, 0, 64, 0, "R8 released frame");
        expect_frame(256, 8'h00, 1, 8'(299), "R8 released overflow keeps end byte");
        store_fwd = 1;
        send(300, 8'h01, 1, 1, 0, 0, 0, "R8");
        expect_empty("R8 unreleased overflow removed");
        store_fwd = 0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_threshold();
        t_store_fwd();
        t_filter();
        t_short();
        t_runt();
        t_pop_idle();
        t_flush();
        t_overflow();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

endmodule